// File: doc/BRIEF.md
# Fast Link Pulse Negotiation Engine

This block exchanges 16-bit link code words with a link partner over single-bit pulse lines and picks the best operating mode that both ends share. The transmitter repeats bursts without pause. Each burst has 33 pulse positions. The positions alternate between clock positions and data positions, and a burst starts and ends on a clock position. Clock positions always carry a pulse. Each data position carries one bit of the local ability word, sent least significant bit first. Between bursts the line stays low for a fixed gap.

The receiver times each pulse against the most recent clock pulse and rebuilds the partner's word from the data positions. It accepts a burst only once the seventeenth clock pulse has arrived, and it treats the partner word as settled after three identical words in a row. A registered resolver then compares the local ability with the settled partner word. It outputs link, speed and duplex using a fixed priority, with no software involved.

The pulse width, the position spacing, the inter-burst gap and the receive tolerance window are all parameters counted in system clock cycles. The receive input is sampled directly, so it must already be synchronous to the clock.

Top module: `flp_neg_top`

## Requirements
- R1: The transmit timing is measured from reset release. `tx_o` is low for GAP cycles, then sends 33 positions of SLOT cycles each, then repeats with a period of GAP+33*SLOT cycles. A pulse is high for the first PULSE_W cycles of its position. Even positions 0, 2, ..., 32 always pulse.
- R2: Odd position 2i+1 carries bit i of `ability_i`, and a pulse means 1. The word is sampled on the last gap cycle before the burst and held for the whole burst.
- R3: The receiver starts a timer at each accepted clock pulse. It accepts a data rising edge when the timer reads SLOT±WIN and the next clock rising edge when the timer reads 2*SLOT±WIN. The first data position after the first clock is bit 0.
- R4: A word is delivered only on the seventeenth accepted clock pulse. Two cases discard the burst and leave the partner outputs unchanged. One is a rising edge outside both windows, which restarts counting from that edge. The other is no clock edge by timer value 2*SLOT+WIN, which returns the receiver to idle.
- R5: `partner_word_o` shows the most recently delivered word in the cycle after the final clock edge is sampled. `partner_vld_o` is high while the last three delivered words are identical, and it drops when a differing word arrives.
- R6: The ability bits are bit 8 for 100BASE-TX full duplex, bit 7 for 100BASE-TX half duplex, bit 6 for 10BASE-T full duplex and bit 5 for 10BASE-T half duplex. While the partner word is valid, the resolver takes the highest common bit in that order. It drives `link_o`=1, sets `speed_100_o`=1 for bits 8 and 7, and sets `full_dup_o`=1 for bits 8 and 6.
- R7: When the partner is valid but no bit is common, `no_common_o`=1 and link, speed and duplex are all 0. When the partner is not valid, all four outputs are 0. The resolver outputs appear one cycle after their inputs.
- R8: During reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ability_i | input | 16 | Local ability word |
| rx_i | input | 1 | Received pulse stream, synchronous to clk_i |
| tx_o | output | 1 | Transmitted pulse stream |
| partner_word_o | output | 16 | Most recent partner word |
| partner_vld_o | output | 1 | Partner word seen three times in a row |
| link_o | output | 1 | A common mode was selected |
| speed_100_o | output | 1 | Selected mode is 100 Mb/s |
| full_dup_o | output | 1 | Selected mode is full duplex |
| no_common_o | output | 1 | Partner valid but no shared mode |

## Verification
The bench drives the receive line and the ability word on falling edges. Its model holds the transmit phase as the number of rising edges since reset release, modulo the period, so `tx_o` is checked on every cycle. A burst's final clock pulse driven before edge n makes `partner_word_o` and `partner_vld_o` due after edge n, and the resolver outputs are due one edge later. The model applies each result in exactly that cycle and compares all outputs on every falling edge. It covers jittered bursts, an aborted burst, a burst with a stray pulse, an ability change with no shared mode, and a loopback of the block's own transmitter.

// File: rtl/flp_pkg.sv
package flp_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned N_POS  = 2 * WORD_W + 1;
  localparam int unsigned B_10HD  = 5;
  localparam int unsigned B_10FD  = 6;
  localparam int unsigned B_100HD = 7;
  localparam int unsigned B_100FD = 8;

  typedef struct packed {
    logic link;
    logic spd100;
    logic fdx;
    logic nomode;
  } mode_t;
endpackage

// File: rtl/flp_tx.sv
module flp_tx
  import flp_pkg::*;
#(
  parameter int unsigned PULSE_W = 2,
  parameter int unsigned SLOT    = 8,
  parameter int unsigned GAP     = 40
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] ability_i,
  output logic              tx_o
);
  localparam int unsigned MAXC = (SLOT > GAP) ? SLOT : GAP;
  localparam int unsigned CW   = $clog2(MAXC + 1);
  localparam int unsigned PPW  = $clog2(N_POS);
  localparam int unsigned BW   = $clog2(WORD_W);

  logic              in_burst_q;
  logic [CW-1:0]     cnt_q;
  logic [PPW-1:0]    pos_q;
  logic [WORD_W-1:0] word_q;
  logic [BW-1:0]     bidx;

  assign bidx = pos_q[BW:1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_burst_q <= 1'b0;
      cnt_q      <= '0;
      pos_q      <= '0;
      word_q     <= '0;
    end else if (!in_burst_q) begin
      if (cnt_q == CW'(GAP - 1)) begin
        in_burst_q <= 1'b1;
        cnt_q      <= '0;
        pos_q      <= '0;
        word_q     <= ability_i;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (cnt_q == CW'(SLOT - 1)) begin
      cnt_q <= '0;
      if (pos_q == PPW'(N_POS - 1)) in_burst_q <= 1'b0;
      else pos_q <= pos_q + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // even positions are clocks, odd positions carry data
  assign tx_o = in_burst_q && (cnt_q < CW'(PULSE_W)) && (!pos_q[0] || word_q[bidx]);
endmodule

// File: rtl/flp_rx.sv
module flp_rx
  import flp_pkg::*;
#(
  parameter int unsigned SLOT = 8,
  parameter int unsigned WIN  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_i,
  output logic [WORD_W-1:0] word_o,
  output logic              vld_o
);
  localparam int unsigned TMAX = 2 * SLOT + WIN;
  localparam int unsigned TW   = $clog2(TMAX + 1) + 1;
  localparam int unsigned NW   = $clog2(WORD_W + 1);

  logic              rx_q, active_q, dseen_q;
  logic [NW-1:0]     nclk_q;
  logic [TW-1:0]     tmr_q;
  logic [WORD_W-2:0] sh_q;
  logic [WORD_W-1:0] last_q;
  logic [1:0]        cnt_q;
  logic              rise, in_d, in_c, d_hit, c_hit, done;
  logic [WORD_W-1:0] new_word;

  assign rise     = rx_i & ~rx_q;
  assign in_d     = (tmr_q >= TW'(SLOT - WIN)) && (tmr_q <= TW'(SLOT + WIN));
  assign in_c     = (tmr_q >= TW'(2 * SLOT - WIN)) && (tmr_q <= TW'(TMAX));
  assign d_hit    = active_q && rise && in_d && !dseen_q;
  assign c_hit    = active_q && rise && in_c && !d_hit;
  assign done     = c_hit && (nclk_q == NW'(WORD_W));
  assign new_word = {dseen_q, sh_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_q     <= 1'b0;
      active_q <= 1'b0;
      dseen_q  <= 1'b0;
      nclk_q   <= '0;
      tmr_q    <= '0;
      sh_q     <= '0;
      last_q   <= '0;
      cnt_q    <= '0;
    end else begin
      rx_q <= rx_i;
      if (!active_q) begin
        if (rise) begin
          active_q <= 1'b1;
          nclk_q   <= NW'(1);
          tmr_q    <= TW'(1);
          dseen_q  <= 1'b0;
        end
      end else if (d_hit) begin
        dseen_q <= 1'b1;
        tmr_q   <= tmr_q + 1'b1;
      end else if (c_hit) begin
        sh_q    <= new_word[WORD_W-1:1];
        dseen_q <= 1'b0;
        tmr_q   <= TW'(1);
        if (done) begin
          active_q <= 1'b0;
          nclk_q   <= '0;
        end else begin
          nclk_q <= nclk_q + 1'b1;
        end
      end else if (rise) begin
        // stray edge: restart, treating it as the first clock
        nclk_q  <= NW'(1);
        tmr_q   <= TW'(1);
        dseen_q <= 1'b0;
      end else if (tmr_q == TW'(TMAX)) begin
        active_q <= 1'b0;
        nclk_q   <= '0;
      end else begin
        tmr_q <= tmr_q + 1'b1;
      end

      if (done) begin
        if (cnt_q != 2'd0 && new_word == last_q) begin
          if (cnt_q != 2'd3) cnt_q <= cnt_q + 1'b1;
        end else begin
          last_q <= new_word;
          cnt_q  <= 2'd1;
        end
      end
    end
  end

  assign word_o = last_q;
  assign vld_o  = (cnt_q == 2'd3);
endmodule

// File: rtl/flp_resolve.sv
module flp_resolve
  import flp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] local_i,
  input  logic [WORD_W-1:0] partner_i,
  input  logic              vld_i,
  output mode_t             mode_o
);
  logic [3:0] common;
  mode_t      mode_d;

  assign common = local_i[B_100FD:B_10HD] & partner_i[B_100FD:B_10HD];

  always_comb begin
    mode_d = '0;
    if (vld_i) begin
      if (common[3]) begin
        mode_d.link = 1'b1; mode_d.spd100 = 1'b1; mode_d.fdx = 1'b1;
      end else if (common[2]) begin
        mode_d.link = 1'b1; mode_d.spd100 = 1'b1;
      end else if (common[1]) begin
        mode_d.link = 1'b1; mode_d.fdx = 1'b1;
      end else if (common[0]) begin
        mode_d.link = 1'b1;
      end else begin
        mode_d.nomode = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_o <= '0;
    else         mode_o <= mode_d;
  end
endmodule

// File: rtl/flp_neg_top.sv
module flp_neg_top
  import flp_pkg::*;
#(
  parameter int unsigned PULSE_W = 2,
  parameter int unsigned SLOT    = 8,
  parameter int unsigned WIN     = 2,
  parameter int unsigned GAP     = 40
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] ability_i,
  input  logic        rx_i,
  output logic        tx_o,
  output logic [15:0] partner_word_o,
  output logic        partner_vld_o,
  output logic        link_o,
  output logic        speed_100_o,
  output logic        full_dup_o,
  output logic        no_common_o
);
  mode_t mode;

  flp_tx #(.PULSE_W(PULSE_W), .SLOT(SLOT), .GAP(GAP)) u_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .ability_i(ability_i), .tx_o(tx_o)
  );

  flp_rx #(.SLOT(SLOT), .WIN(WIN)) u_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .rx_i(rx_i),
    .word_o(partner_word_o), .vld_o(partner_vld_o)
  );

  flp_resolve u_res (
    .clk_i(clk_i), .rst_ni(rst_ni), .local_i(ability_i),
    .partner_i(partner_word_o), .vld_i(partner_vld_o), .mode_o(mode)
  );

  assign link_o      = mode.link;
  assign speed_100_o = mode.spd100;
  assign full_dup_o  = mode.fdx;
  assign no_common_o = mode.nomode;
endmodule

// File: rtl/flp_neg_chk.sv
module flp_neg_chk
  import flp_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic [15:0] ability_i,
  input logic [15:0] partner_word_o,
  input logic        partner_vld_o,
  input logic        link_o,
  input logic        speed_100_o,
  input logic        full_dup_o,
  input logic        no_common_o
);
  p_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(link_o && no_common_o));

  p_link_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_o |-> $past(partner_vld_o));

  p_mode_link_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (speed_100_o || full_dup_o) |-> link_o);

  p_vld_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (partner_vld_o && $past(partner_vld_o)) |-> $stable(partner_word_o));

  p_none_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    no_common_o |-> ($past(partner_vld_o) &&
      (($past(ability_i[B_100FD:B_10HD]) & $past(partner_word_o[B_100FD:B_10HD])) == 4'd0)));
endmodule

bind flp_neg_top flp_neg_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ability_i(ability_i),
  .partner_word_o(partner_word_o), .partner_vld_o(partner_vld_o),
  .link_o(link_o), .speed_100_o(speed_100_o), .full_dup_o(full_dup_o),
  .no_common_o(no_common_o)
);

// File: tb/flp_neg_top_bench.sv
`timescale 1ns/1ps
module flp_neg_top_bench;
  localparam int PW = 2;
  localparam int SL = 8;
  localparam int WN = 2;
  localparam int GP = 40;
  localparam int P  = GP + 33 * SL;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] ability = 16'h01E1;
  logic        rx = 1'b0;
  logic        tx_o, partner_vld_o, link_o, speed_100_o, full_dup_o, no_common_o;
  logic [15:0] partner_word_o;

  int checks = 0;
  int fails  = 0;

  // model state
  int          k = 0;
  logic [15:0] txw = 16'h0;
  logic [15:0] mlast = 16'h0;
  int          mcnt = 0;
  logic        pend = 1'b0;
  logic [15:0] pendw = 16'h0;
  logic [3:0]  e_mode = 4'h0;  // {link, spd100, fdx, nomode}
  logic [15:0] ab_next = 16'h01E1;

  always #2 clk = ~clk;

  flp_neg_top u_flp_neg_top (
    .clk_i(clk), .rst_ni(rst_ni), .ability_i(ability), .rx_i(rx), .tx_o(tx_o),
    .partner_word_o(partner_word_o), .partner_vld_o(partner_vld_o),
    .link_o(link_o), .speed_100_o(speed_100_o), .full_dup_o(full_dup_o),
    .no_common_o(no_common_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h at t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic exp_tx(input int kk);
    int ph, off, pos, c;
    ph = kk % P;
    if (ph < GP) return 1'b0;
    off = ph - GP;
    pos = off / SL;
    c   = off % SL;
    if (pos % 2 == 0) return (c < PW);
    return (c < PW) && txw[pos/2];
  endfunction

  function automatic logic [3:0] resolve(input bit v, input logic [15:0] a, input logic [15:0] p);
    logic [15:0] cm;
    cm = a & p;
    if (!v)     return 4'b0000;
    if (cm[8])  return 4'b1110;
    if (cm[7])  return 4'b1100;
    if (cm[6])  return 4'b1010;
    if (cm[5])  return 4'b1000;
    return 4'b0001;
  endfunction

  task automatic step(input logic rxv, input logic fin, input logic [15:0] fw, input bit loopm);
    logic [3:0] act;
    @(negedge clk);
    k++;
    if (pend) begin
      if (mcnt != 0 && pendw == mlast) begin
        if (mcnt < 3) mcnt++;
      end else begin
        mlast = pendw;
        mcnt  = 1;
      end
      pend = 1'b0;
    end
    chk(tx_o == exp_tx(k), "R1/R2 tx_o", {15'h0, tx_o}, {15'h0, exp_tx(k)});
    chk(partner_word_o == mlast, "R3/R5 partner_word_o", partner_word_o, mlast);
    chk(partner_vld_o == (mcnt == 3), "R5 partner_vld_o", {15'h0, partner_vld_o}, {15'h0, mcnt == 3});
    act = {link_o, speed_100_o, full_dup_o, no_common_o};
    chk(act == e_mode, "R6/R7 mode", {12'h0, act}, {12'h0, e_mode});
    ability = ab_next;
    if (loopm) begin
      rx = exp_tx(k);
      pend  = ((k % P) == GP + 32 * SL);
      pendw = txw;
    end else begin
      rx = rxv;
      pend  = fin;
      pendw = fw;
    end
    e_mode = resolve(mcnt == 3, ability, mlast);
    if ((k % P) == GP - 1) txw = ability;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 16'h0, 1'b0);
  endtask

  // mode 0 good, 1 aborted after 10 clocks, 2 jittered data, 3 stray pulse
  task automatic send(input logic [15:0] w, input int mode);
    int len;
    len = 32 * SL + PW + 2 * SL + WN + 8;
    for (int t = 0; t < len; t++) begin
      logic hi;
      hi = 1'b0;
      for (int n = 0; n <= 16; n++)
        if ((mode != 1 || n < 10) && t >= 2 * n * SL && t < 2 * n * SL + PW) hi = 1'b1;
      for (int i = 0; i < 16; i++) begin
        int s;
        s = (2 * i + 1) * SL + ((mode == 2) ? ((i % 2 == 0) ? WN : -WN) : 0);
        if (w[i] && (mode != 1 || i < 9) && t >= s && t < s + PW) hi = 1'b1;
      end
      if (mode == 3 && t >= SL + WN + 1 && t < SL + WN + 1 + PW) hi = 1'b1;
      step(hi, (t == 32 * SL) && (mode == 0 || mode == 2), w, 1'b0);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    chk({tx_o, partner_vld_o, link_o, speed_100_o, full_dup_o, no_common_o} == 6'b0,
        "R8 outputs in reset", {10'h0, tx_o, partner_vld_o, link_o, speed_100_o, full_dup_o, no_common_o}, 16'h0);
    chk(partner_word_o == 16'h0, "R8 partner_word_o in reset", partner_word_o, 16'h0);
    rst_ni = 1'b1;
    k = 0;
    idle(10);

    send(16'h0041, 0); send(16'h0041, 0);
    chk(partner_vld_o == 1'b0, "R5 two words not enough", {15'h0, partner_vld_o}, 16'h0);
    send(16'h0041, 0);
    chk(partner_vld_o == 1'b1, "R5 three words valid", {15'h0, partner_vld_o}, 16'h1);
    idle(2);
    chk({link_o, speed_100_o, full_dup_o} == 3'b101, "R6 10 full", {13'h0, link_o, speed_100_o, full_dup_o}, 16'h5);

    send(16'h00A1, 0);
    chk(partner_vld_o == 1'b0, "R5 differing word clears", {15'h0, partner_vld_o}, 16'h0);
    send(16'h00A1, 0); send(16'h00A1, 0); idle(2);
    chk({link_o, speed_100_o, full_dup_o} == 3'b110, "R6 100 half", {13'h0, link_o, speed_100_o, full_dup_o}, 16'h6);

    send(16'h0181, 0); send(16'h0181, 0); send(16'h0181, 0); idle(2);
    chk({link_o, speed_100_o, full_dup_o} == 3'b111, "R6 100 full", {13'h0, link_o, speed_100_o, full_dup_o}, 16'h7);

    ab_next = 16'h0021; idle(4);
    chk(no_common_o == 1'b1 && link_o == 1'b0, "R7 no common mode", {14'h0, no_common_o, link_o}, 16'h2);

    ab_next = 16'h0061;
    send(16'h0021, 0); send(16'h0021, 0); send(16'h0021, 0); idle(2);
    chk({link_o, speed_100_o, full_dup_o} == 3'b100, "R6 10 half", {13'h0, link_o, speed_100_o, full_dup_o}, 16'h4);

    send(16'h0121, 1);
    chk(partner_vld_o == 1'b1 && partner_word_o == 16'h0021, "R4 aborted burst ignored", partner_word_o, 16'h0021);
    send(16'h0040, 3);
    chk(partner_vld_o == 1'b1 && partner_word_o == 16'h0021, "R4 stray pulse burst ignored", partner_word_o, 16'h0021);

    send(16'h5A41, 2);
    chk(partner_word_o == 16'h5A41, "R3 jittered burst accepted", partner_word_o, 16'h5A41);
    send(16'h5A41, 2); send(16'h5A41, 2); idle(2);
    chk(partner_vld_o == 1'b1, "R3 jittered words stable", {15'h0, partner_vld_o}, 16'h1);

    // loopback of own transmitter
    ab_next = 16'h01E1;
    while ((k % P) != P - 1) idle(1);
    for (int i = 0; i < 4 * P; i++) step(1'b0, 1'b0, 16'h0, 1'b1);
    idle(2);
    chk(partner_word_o == 16'h01E1, "R2 loopback word", partner_word_o, 16'h01E1);
    chk({link_o, speed_100_o, full_dup_o} == 3'b111, "R6 loopback 100 full", {13'h0, link_o, speed_100_o, full_dup_o}, 16'h7);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule